// File: doc/BRIEF.md
# Byte Data-Bus-Inversion and Write-Mask Codec

This block handles the one-per-byte side signal that travels with a DRAM data lane pair. This signal is called the inversion/mask line here. On the sending side, each byte whose weight is five or more set bits is sent complemented, with its side line high. This keeps the number of lines driven high at or below four per byte. The same side line also marks bytes that a masked write must leave untouched. Its meaning depends on whether write inversion is switched on. With inversion off, a high side line marks a dropped byte. With inversion on, the block sends a byte of all ones with the side line low. The inverter can never produce that pattern.

On the receiving side the block undoes the inversion, returns the original bytes, and produces one write-enable per byte. Read and write inversion are switched on and off by two separate configuration inputs. The operation type (read, write or masked write) comes with every transfer. The encode and decode paths are purely combinational, and each is followed by one register stage with a clock enable.

Top module: `dbi_mask_codec`

## Requirements
- R1: While reset is asserted, and after it, until a valid transfer is captured, `tx_out_valid` and `rx_out_valid` are 0, and all registered data, side-line and write-enable outputs are 0.
- R2: Each output path has exactly one cycle of latency: `*_out_valid` is high in the cycle after a `*_valid` input and low otherwise. The registered data holds its value when no valid input arrives.
- R3: On transmit, when inversion is on for the operation's direction and a byte (not masked) has five or more set bits, the byte is sent complemented and its side line is 1. The sent byte then has at most three set bits.
- R4: On transmit, a byte with four or fewer set bits (including exactly four) is sent unchanged with its side line 0.
- R5: On transmit, when inversion is off for the direction (`cfg_rd_inv_en` for reads with `tx_op_write`=0, `cfg_wr_inv_en` for writes), every byte that is not masked is sent unchanged with its side line 0.
- R6: On transmit, for a masked write (`tx_op_write`=1, `tx_op_masked`=1) with write inversion off, a byte whose `tx_mask` bit is 1 is sent unchanged with its side line 1.
- R7: On transmit, for a masked write with write inversion on, a byte whose `tx_mask` bit is 1 is sent as all ones (0xFF) with its side line 0. The other bytes follow R3/R4.
- R8: `tx_mask` has no effect on reads or on writes with `tx_op_masked`=0. `tx_op_masked` has no effect on reads.
- R9: On receive, when inversion is on for the direction and the transfer is not a masked write, a byte with side line 1 is complemented, and a byte with side line 0 passes unchanged.
- R10: On receive, when inversion is off for the direction and the transfer is not a masked write, the side line is ignored and the data passes unchanged. All write-enables are 1 on reads and on writes that are not masked.
- R11: On receive, for a masked write with write inversion off, a byte's write-enable is the inverse of its side line, and its data passes unchanged.
- R12: On receive, for a masked write with write inversion on, a byte with side line 0 and five or more set bits has write-enable 0 and passes unchanged. Every other byte has write-enable 1 and is decoded as in R9.
- R13: A transmit output fed back into the receiver with the same operation and configuration restores every unmasked byte. The write-enable of each byte is the inverse of its mask bit on masked writes, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_rd_inv_en | input | 1 | Inversion on for reads |
| cfg_wr_inv_en | input | 1 | Inversion on for writes |
| tx_valid | input | 1 | Transmit input holds a transfer |
| tx_op_write | input | 1 | Transmit transfer is a write (0 = read) |
| tx_op_masked | input | 1 | Transmit write is a masked write |
| tx_mask | input | LANES | Per byte: 1 = byte must not be written |
| tx_data | input | LANES*BYTE_W | Original data to send |
| tx_out_valid | output | 1 | Registered transmit output is new |
| tx_line | output | LANES*BYTE_W | Data as driven on the lines |
| tx_dmi | output | LANES | Per-byte inversion/mask side line |
| rx_valid | input | 1 | Receive input holds a transfer |
| rx_op_write | input | 1 | Received transfer is a write (0 = read) |
| rx_op_masked | input | 1 | Received write is a masked write |
| rx_line | input | LANES*BYTE_W | Data as seen on the lines |
| rx_dmi | input | LANES | Received per-byte side line |
| rx_out_valid | output | 1 | Registered receive output is new |
| rx_data | output | LANES*BYTE_W | Restored data |
| rx_wr_en | output | LANES | Per-byte write-enable |

## Verification
The hardest case to reach is a masked write with write inversion on, in which a masked byte has to be told apart from a normal byte. Both arrive with the side line low. The only difference is the weight of the byte, and the encoder never produces the heavy pattern on its own. The bench loops each encoded transfer back into the receiver. It also drives heavy, side-line-low bytes into the receiver directly. Next to these it sends bytes of exactly four set bits and inverted bytes, so that both sides of the weight boundary are covered in that mode.

// File: rtl/dbi_codec_pkg.sv
package dbi_codec_pkg;

  // Transfer class derived from the operation inputs
  typedef enum logic [1:0] {
    XFER_READ        = 2'd0,
    XFER_WRITE       = 2'd1,
    XFER_MASKED_WR   = 2'd2
  } xfer_kind_e;

  function automatic xfer_kind_e classify(input logic is_write, input logic is_masked);
    xfer_kind_e kind;
    if (!is_write)      kind = XFER_READ;
    else if (is_masked) kind = XFER_MASKED_WR;
    else                kind = XFER_WRITE;
    return kind;
  endfunction

  // Inversion enable that applies to a transfer class
  function automatic logic inv_for(input xfer_kind_e kind, input logic rd_en, input logic wr_en);
    return (kind == XFER_READ) ? rd_en : wr_en;
  endfunction

endpackage

// File: rtl/dbi_rst_sync.sv
module dbi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/dbi_heavy_detect.sv
module dbi_heavy_detect #(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] bits,
  output logic              heavy
);
  localparam int CNT_W     = $clog2(BYTE_W + 1);
  localparam int HEAVY_MIN = BYTE_W / 2 + 1;

  logic [CNT_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int b = 0; b < BYTE_W; b++) begin
      ones = ones + CNT_W'(bits[b]);
    end
    heavy = (ones >= CNT_W'(HEAVY_MIN));
  end
endmodule

// File: rtl/dbi_byte_enc.sv
module dbi_byte_enc
  import dbi_codec_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  xfer_kind_e        kind,
  input  logic              inv_en,
  input  logic              mask_bit,
  input  logic [BYTE_W-1:0] data,
  output logic [BYTE_W-1:0] line,
  output logic              side
);
  logic heavy;

  dbi_heavy_detect #(.BYTE_W(BYTE_W)) u_weight (
    .bits  (data),
    .heavy (heavy)
  );

  always_comb begin
    line = data;
    side = 1'b0;
    if (kind == XFER_MASKED_WR && mask_bit) begin
      if (inv_en) begin
        line = '1;     // pattern the inverter never emits
        side = 1'b0;
      end else begin
        side = 1'b1;
      end
    end else if (inv_en && heavy) begin
      line = ~data;
      side = 1'b1;
    end
  end
endmodule

// File: rtl/dbi_byte_dec.sv
module dbi_byte_dec
  import dbi_codec_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  xfer_kind_e        kind,
  input  logic              inv_en,
  input  logic [BYTE_W-1:0] line,
  input  logic              side,
  output logic [BYTE_W-1:0] data,
  output logic              wr_en
);
  logic heavy;

  dbi_heavy_detect #(.BYTE_W(BYTE_W)) u_weight (
    .bits  (line),
    .heavy (heavy)
  );

  always_comb begin
    data  = line;
    wr_en = 1'b1;
    if (kind == XFER_MASKED_WR) begin
      if (!inv_en) begin
        wr_en = ~side;
      end else if (!side && heavy) begin
        wr_en = 1'b0;
      end else if (side) begin
        data = ~line;
      end
    end else if (inv_en && side) begin
      data = ~line;
    end
  end
endmodule

// File: rtl/dbi_mask_codec.sv
module dbi_mask_codec
  import dbi_codec_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_rd_inv_en,
  input  logic                      cfg_wr_inv_en,
  input  logic                      tx_valid,
  input  logic                      tx_op_write,
  input  logic                      tx_op_masked,
  input  logic [LANES-1:0]          tx_mask,
  input  logic [LANES*BYTE_W-1:0]   tx_data,
  output logic                      tx_out_valid,
  output logic [LANES*BYTE_W-1:0]   tx_line,
  output logic [LANES-1:0]          tx_dmi,
  input  logic                      rx_valid,
  input  logic                      rx_op_write,
  input  logic                      rx_op_masked,
  input  logic [LANES*BYTE_W-1:0]   rx_line,
  input  logic [LANES-1:0]          rx_dmi,
  output logic                      rx_out_valid,
  output logic [LANES*BYTE_W-1:0]   rx_data,
  output logic [LANES-1:0]          rx_wr_en
);
  localparam int DATA_W = LANES * BYTE_W;

  logic rst_sync_n;

  dbi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  xfer_kind_e tx_kind, rx_kind;
  logic       tx_inv, rx_inv;

  always_comb begin
    tx_kind = classify(tx_op_write, tx_op_masked);
    rx_kind = classify(rx_op_write, rx_op_masked);
    tx_inv  = inv_for(tx_kind, cfg_rd_inv_en, cfg_wr_inv_en);
    rx_inv  = inv_for(rx_kind, cfg_rd_inv_en, cfg_wr_inv_en);
  end

  logic [DATA_W-1:0] enc_line, dec_data;
  logic [LANES-1:0]  enc_side, dec_we;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dbi_byte_enc #(.BYTE_W(BYTE_W)) u_enc (
      .kind     (tx_kind),
      .inv_en   (tx_inv),
      .mask_bit (tx_mask[g]),
      .data     (tx_data[g*BYTE_W +: BYTE_W]),
      .line     (enc_line[g*BYTE_W +: BYTE_W]),
      .side     (enc_side[g])
    );
    dbi_byte_dec #(.BYTE_W(BYTE_W)) u_dec (
      .kind   (rx_kind),
      .inv_en (rx_inv),
      .line   (rx_line[g*BYTE_W +: BYTE_W]),
      .side   (rx_dmi[g]),
      .data   (dec_data[g*BYTE_W +: BYTE_W]),
      .wr_en  (dec_we[g])
    );
  end

  // Output stage: next-state with explicit clock enables
  logic              tx_vld_d, tx_vld_q, rx_vld_d, rx_vld_q;
  logic [DATA_W-1:0] tx_line_d, tx_line_q, rx_data_d, rx_data_q;
  logic [LANES-1:0]  tx_side_d, tx_side_q, rx_we_d, rx_we_q;

  always_comb begin
    tx_vld_d  = tx_valid;
    rx_vld_d  = rx_valid;
    tx_line_d = tx_line_q;
    tx_side_d = tx_side_q;
    rx_data_d = rx_data_q;
    rx_we_d   = rx_we_q;
    if (tx_valid) begin
      tx_line_d = enc_line;
      tx_side_d = enc_side;
    end
    if (rx_valid) begin
      rx_data_d = dec_data;
      rx_we_d   = dec_we;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_vld_q  <= 1'b0;
      rx_vld_q  <= 1'b0;
      tx_line_q <= '0;
      tx_side_q <= '0;
      rx_data_q <= '0;
      rx_we_q   <= '0;
    end else begin
      tx_vld_q  <= tx_vld_d;
      rx_vld_q  <= rx_vld_d;
      tx_line_q <= tx_line_d;
      tx_side_q <= tx_side_d;
      rx_data_q <= rx_data_d;
      rx_we_q   <= rx_we_d;
    end
  end

  assign tx_out_valid = tx_vld_q;
  assign tx_line      = tx_line_q;
  assign tx_dmi       = tx_side_q;
  assign rx_out_valid = rx_vld_q;
  assign rx_data      = rx_data_q;
  assign rx_wr_en     = rx_we_q;
endmodule

// File: rtl/dbi_codec_checks.sv
module dbi_codec_checks #(
  parameter int LANES  = 2,
  parameter int BYTE_W = 8
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic                    cfg_rd_inv_en,
  input logic                    cfg_wr_inv_en,
  input logic                    tx_valid,
  input logic                    tx_op_write,
  input logic                    tx_op_masked,
  input logic [LANES-1:0]        tx_mask,
  input logic                    tx_out_valid,
  input logic [LANES*BYTE_W-1:0] tx_line,
  input logic [LANES-1:0]        tx_dmi,
  input logic                    rx_valid,
  input logic                    rx_op_write,
  input logic                    rx_op_masked,
  input logic [LANES-1:0]        rx_dmi,
  input logic                    rx_out_valid,
  input logic [LANES-1:0]        rx_wr_en
);
  localparam int LIGHT_MAX = BYTE_W / 2;

  logic tx_inv_now, tx_mw_now, rx_mw_now;
  assign tx_inv_now = tx_op_write ? cfg_wr_inv_en : cfg_rd_inv_en;
  assign tx_mw_now  = tx_op_write && tx_op_masked;
  assign rx_mw_now  = rx_op_write && rx_op_masked;

  assert_tx_latency_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tx_valid |=> tx_out_valid);
  assert_tx_idle_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !tx_valid |=> !tx_out_valid);
  assert_rx_latency_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_valid |=> rx_out_valid);

  assert_rx_unmasked_we_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rx_valid && !rx_mw_now) |=> (rx_wr_en == '1));

  for (genvar g = 0; g < LANES; g++) begin : g_byte
    assert_light_line_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (tx_valid && tx_inv_now && !(tx_mw_now && tx_mask[g]))
      |=> ($countones(tx_line[g*BYTE_W +: BYTE_W]) <= LIGHT_MAX));

    assert_mask_plain_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (tx_valid && tx_mw_now && tx_mask[g] && !cfg_wr_inv_en) |=> tx_dmi[g]);

    assert_mask_pattern_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (tx_valid && tx_mw_now && tx_mask[g] && cfg_wr_inv_en)
      |=> (!tx_dmi[g] && (tx_line[g*BYTE_W +: BYTE_W] == '1)));

    assert_rx_mask_plain_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (rx_valid && rx_mw_now && !cfg_wr_inv_en) |=> (rx_wr_en[g] == !$past(rx_dmi[g])));
  end
endmodule

bind dbi_mask_codec dbi_codec_checks #(.LANES(LANES), .BYTE_W(BYTE_W)) u_checks (.*);

// File: tb/dbi_mask_codec_test.sv
module dbi_mask_codec_test;
  localparam int LANES  = 2;
  localparam int BYTE_W = 8;
  localparam int DW     = LANES * BYTE_W;
  localparam int NV     = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_rd_inv_en = 1'b0, cfg_wr_inv_en = 1'b0;
  logic          tx_valid = 1'b0, tx_op_write = 1'b0, tx_op_masked = 1'b0;
  logic [1:0]    tx_mask = '0;
  logic [DW-1:0] tx_data = '0;
  logic          tx_out_valid;
  logic [DW-1:0] tx_line;
  logic [1:0]    tx_dmi;
  logic          rx_valid = 1'b0, rx_op_write = 1'b0, rx_op_masked = 1'b0;
  logic [DW-1:0] rx_line = '0;
  logic [1:0]    rx_dmi = '0;
  logic          rx_out_valid;
  logic [DW-1:0] rx_data;
  logic [1:0]    rx_wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbi_mask_codec #(.LANES(LANES), .BYTE_W(BYTE_W)) uut (.*);

  // {write, masked, rd_inv, wr_inv, mask[1:0], data, expected line, expected side}
  localparam logic [39:0] TX_VEC [NV] = '{
    {1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 16'hF01F, 16'hF0E0, 2'b01}, // R3 R4
    {1'b0, 1'b0, 1'b0, 1'b1, 2'b00, 16'hFF7F, 16'hFF7F, 2'b00}, // R5 read off
    {1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 16'hFE03, 16'h0103, 2'b10}, // R3 R8
    {1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 16'hFFFF, 16'hFFFF, 2'b00}, // R5 write off
    {1'b1, 1'b1, 1'b1, 1'b0, 2'b10, 16'hAAFF, 16'hAAFF, 2'b10}, // R6
    {1'b1, 1'b1, 1'b0, 1'b1, 2'b01, 16'h0FF8, 16'h0FFF, 2'b00}, // R7 R4
    {1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 16'h00EF, 16'hFF10, 2'b01}, // R7 R3
    {1'b0, 1'b1, 1'b1, 1'b1, 2'b11, 16'h3CC7, 16'h3C38, 2'b01}, // R8
    {1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 16'h1234, 16'h1234, 2'b00}, // R6 no mask
    {1'b1, 1'b0, 1'b1, 1'b1, 2'b00, 16'h80E0, 16'h80E0, 2'b00}  // R4
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic rx_case(input logic wr, input logic msk, input logic rinv, input logic winv,
                         input logic [15:0] line, input logic [1:0] side,
                         input logic [15:0] exp_data, input logic [1:0] exp_we, input string tag);
    @(negedge clk);
    cfg_rd_inv_en = rinv; cfg_wr_inv_en = winv;
    rx_op_write = wr; rx_op_masked = msk; rx_line = line; rx_dmi = side; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    chk(rx_out_valid == 1'b1, {tag, " valid"}, 32'(rx_out_valid), 32'd1);
    chk(rx_data == exp_data, {tag, " data"}, 32'(rx_data), 32'(exp_data));
    chk(rx_wr_en == exp_we, {tag, " write-enable"}, 32'(rx_wr_en), 32'(exp_we));
  endtask

  task automatic reset_outputs_zero(input string tag);
    chk(tx_out_valid == 1'b0 && rx_out_valid == 1'b0, {tag, " valids"},
        32'({tx_out_valid, rx_out_valid}), 32'd0);
    chk(tx_line == '0 && tx_dmi == '0, {tag, " tx regs"}, 32'({tx_line, tx_dmi}), 32'd0);
    chk(rx_data == '0 && rx_wr_en == '0, {tag, " rx regs"}, 32'({rx_data, rx_wr_en}), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    reset_outputs_zero("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reset_outputs_zero("R1 after release");

    // Table walk: encode, then feed the encoding back through the decoder
    for (int i = 0; i < NV; i++) begin
      logic        wr, msk, rinv, winv;
      logic [1:0]  mask, eside, exp_we;
      logic [15:0] data, eline;
      {wr, msk, rinv, winv, mask, data, eline, eside} = TX_VEC[i];
      @(negedge clk);
      cfg_rd_inv_en = rinv; cfg_wr_inv_en = winv;
      tx_op_write = wr; tx_op_masked = msk; tx_mask = mask; tx_data = data; tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      chk(tx_out_valid == 1'b1, $sformatf("R2 tx valid vec %0d", i), 32'(tx_out_valid), 32'd1);
      chk(tx_line == eline, $sformatf("R3/R4/R5/R6/R7/R8 line vec %0d", i), 32'(tx_line), 32'(eline));
      chk(tx_dmi == eside, $sformatf("R3/R4/R5/R6/R7/R8 side vec %0d", i), 32'(tx_dmi), 32'(eside));
      rx_op_write = wr; rx_op_masked = msk; rx_line = tx_line; rx_dmi = tx_dmi; rx_valid = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0;
      exp_we = (wr && msk) ? ~mask : 2'b11;
      chk(rx_wr_en == exp_we, $sformatf("R13 loop write-enable vec %0d", i), 32'(rx_wr_en), 32'(exp_we));
      for (int b = 0; b < LANES; b++) begin
        if (exp_we[b])
          chk(rx_data[b*8 +: 8] == data[b*8 +: 8], $sformatf("R13 loop byte %0d vec %0d", b, i),
              32'(rx_data[b*8 +: 8]), 32'(data[b*8 +: 8]));
      end
    end

    // R2: no valid input, outputs idle and held
    @(negedge clk);
    chk(tx_out_valid == 1'b0 && rx_out_valid == 1'b0, "R2 idle valids",
        32'({tx_out_valid, rx_out_valid}), 32'd0);
    chk(tx_line == 16'h80E0, "R2 tx line held", 32'(tx_line), 32'h80E0);

    // Directed receive cases
    rx_case(1'b0, 1'b0, 1'b0, 1'b1, 16'h5AA5, 2'b11, 16'h5AA5, 2'b11, "R10 read inversion off");
    rx_case(1'b0, 1'b0, 1'b1, 1'b0, 16'h01FE, 2'b10, 16'hFEFE, 2'b11, "R9 read inversion on");
    rx_case(1'b1, 1'b0, 1'b0, 1'b1, 16'h03E0, 2'b11, 16'hFC1F, 2'b11, "R9 write inversion on");
    rx_case(1'b1, 1'b1, 1'b1, 1'b0, 16'h7788, 2'b01, 16'h7788, 2'b10, "R11 masked, inversion off");
    rx_case(1'b1, 1'b1, 1'b0, 1'b1, 16'hFF1F, 2'b00, 16'hFF1F, 2'b00, "R12 heavy low-side bytes");
    rx_case(1'b1, 1'b1, 1'b0, 1'b1, 16'h0F10, 2'b01, 16'h0FEF, 2'b11, "R12 light and inverted bytes");

    // R1: reset in the middle of traffic clears everything
    @(negedge clk);
    tx_data = 16'hFFFF; tx_op_write = 1'b0; cfg_rd_inv_en = 1'b1; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    #2 rst_n = 1'b0;
    #1 reset_outputs_zero("R1 mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    reset_outputs_zero("R1 after second release");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule